// File: doc/BRIEF.md
# E1 Spare-Bit Buffers

This block handles the five spare national bits (Sa4 to Sa8) that ride in timeslot 0 of every second frame of an E1 CRC-4 multiframe. A framer upstream supplies one parallel timeslot-0 octet per frame. It also gives a strobe on frame 0 of each multiframe. On receive, the block collects each spare-bit position over the eight odd frames into a byte of its own. It hands all five bytes to a processor together once the multiframe is complete. It also flags the start of every multiframe and raises maskable change-of-state interrupts, either for whole bytes or for half-byte nibbles.

On transmit, a processor writes five bytes. The block spreads them back over the odd frames of the outgoing timeslot 0. Two 5-bit selections change this per bit position. The first copies the bit from the system stream unchanged. The second gives the bit to a data-link source, and this one always wins. Line coding, alignment search and CRC are handled elsewhere.

Top module: `e1_spare_bits`

## Requirements
- R1: After reset all five receive bytes read zero, `irqStatus` is zero, `irq` is low and `txLineValid` is low.
- R2: Within an octet, bit 4 carries Sa4, bit 3 Sa5, bit 2 Sa6, bit 1 Sa7 and bit 0 Sa8. The spare bit of frame 2j+1 lands in bit 7-j of its byte, so frame 1 fills the MSB. The byte for Sa(4+k) appears on `rxSaBufs[8k+7:8k]`. Even frames and octet bits 7..5 leave the bytes unchanged.
- R3: The receive bytes change only one cycle after the frame-15 octet is accepted. A read in the middle of a multiframe returns the previous complete multiframe.
- R4: `irqStatus[0]` sets one cycle after every frame-0 octet is accepted.
- R5: `irqStatus[1]` sets at the end of frame 15 if some Sa5..Sa8 byte is enabled in `cosBitEn` and differs from the previous multiframe. `cosBitEn` bit 3 enables Sa5 and bit 0 enables Sa8. Sa4 never sets it. There is no comparison for the first complete multiframe after reset.
- R6: `irqStatus[2]` sets if a position enabled in `cosNibEn` shows a changed nibble against the previous multiframe. `cosNibEn` uses the same bit order as the octet. The upper nibble is compared at frame 7 and the lower nibble at frame 15, from the second complete multiframe on.
- R7: Status bits are sticky. A 1 on `stsClear[i]` clears bit i, and a new set in the same cycle wins over the clear.
- R8: `irq` is high exactly when `irqStatus & irqMask` is non-zero.
- R9: A transmit octet comes out one cycle later. In odd frames, bits 4..0 are replaced by the active transmit byte bit for that frame, using the R2 mapping. Even frames and bits 7..5 pass unchanged.
- R10: A 1 in `transpSel[p]` keeps octet bit p from the system stream in odd frames.
- R11: A 1 in `dlSel[p]` sends `dlBits[p]` in bit p of odd frames, taking precedence over R10 and R9.
- R12: A transmit byte write (`txWrSel` 0..4 selects Sa4..Sa8, values 5..7 are ignored) becomes active at the next transmit frame-0 octet and not before.
- R13: Until the first multiframe strobe on a side, that side ignores the frame count: receive octets change nothing and transmit octets pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Receive timeslot-0 octet valid |
| rxMfSync | input | 1 | With rxValid: this octet is frame 0 |
| rxOctet | input | 8 | Receive timeslot-0 octet |
| txValid | input | 1 | Transmit timeslot-0 octet valid |
| txMfSync | input | 1 | With txValid: this octet is frame 0 |
| txOctet | input | 8 | System-stream timeslot-0 octet |
| dlSel | input | 5 | Per-bit data-link assignment |
| dlBits | input | 5 | Data-link bits for the current frame |
| transpSel | input | 5 | Per-bit transparent copy from system stream |
| txWrEn | input | 1 | Transmit byte write strobe |
| txWrSel | input | 3 | Transmit byte select |
| txWrData | input | 8 | Transmit byte data |
| cosBitEn | input | 4 | Byte change enables, Sa5..Sa8 |
| cosNibEn | input | 5 | Nibble change enables, Sa4..Sa8 |
| irqMask | input | 3 | Interrupt enables per status bit |
| stsClear | input | 3 | Write-one-to-clear of status bits |
| rxSaBufs | output | 40 | Five committed receive bytes |
| irqStatus | output | 3 | Sticky status {nibble, byte, multiframe start} |
| irq | output | 1 | Masked interrupt |
| txLineValid | output | 1 | Transmit octet valid |
| txLineOctet | output | 8 | Transmit octet towards the line |

## Verification
Receive multiframes carry random spare bytes that are sometimes kept and sometimes changed from the previous multiframe, with random enables. This separates real changes from repeats and enabled positions from disabled ones. Directed multiframes change only Sa4, or only one lower nibble, to single out the exclusion and nibble-timing rules. A mid-multiframe read separates atomic commit from a live shift. Transmit frames mix random data-link and transparent selections with buffer writes made in the middle of a multiframe. This exposes priority order, slot mapping and the snapshot point.

// File: rtl/e1_spare_bits_pkg.sv
`timescale 1ns/1ps
package e1_spare_bits_pkg;
  localparam int SA_COUNT    = 5;
  localparam int FRAME_COUNT = 16;
  localparam int SLOT_COUNT  = FRAME_COUNT / 2;
  localparam int SLOT_W      = $clog2(SLOT_COUNT);
  localparam int FRAME_W     = $clog2(FRAME_COUNT);

  typedef struct packed {
    logic              rxCapture;
    logic              rxMidNib;
    logic              rxCommit;
    logic              rxMfBegin;
    logic [SLOT_W-1:0] rxSlot;
    logic              txInsert;
    logic              txLoad;
    logic [SLOT_W-1:0] txSlot;
  } strobeT;
endpackage

// File: rtl/e1_spare_bits_ctrl.sv
`timescale 1ns/1ps
module e1_spare_bits_ctrl
  import e1_spare_bits_pkg::*;
#(
  parameter int FRAMES = FRAME_COUNT
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   rxValid,
  input  logic   rxMfSync,
  input  logic   txValid,
  input  logic   txMfSync,
  output strobeT st
);
  localparam int FW = $clog2(FRAMES);
  localparam logic [FW-1:0] MID_FRAME  = FW'(FRAMES / 2 - 1);
  localparam logic [FW-1:0] LAST_FRAME = FW'(FRAMES - 1);

  logic [FW-1:0] rxCnt, txCnt, rxFrame, txFrame;
  logic rxLocked, txLocked, rxOn, txOn;

  always_comb begin
    rxFrame = rxMfSync ? '0 : rxCnt;
    txFrame = txMfSync ? '0 : txCnt;
    rxOn    = rxValid && (rxMfSync || rxLocked);
    txOn    = txValid && (txMfSync || txLocked);
    st.rxCapture = rxOn && rxFrame[0];
    st.rxMidNib  = rxOn && (rxFrame == MID_FRAME);
    st.rxCommit  = rxOn && (rxFrame == LAST_FRAME);
    st.rxMfBegin = rxOn && (rxFrame == '0);
    st.rxSlot    = rxFrame[FW-1:1];
    st.txInsert  = txOn && txFrame[0];
    st.txLoad    = txOn && (txFrame == '0);
    st.txSlot    = txFrame[FW-1:1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxCnt <= '0; rxLocked <= 1'b0;
      txCnt <= '0; txLocked <= 1'b0;
    end else begin
      if (rxValid) begin
        if (rxMfSync) begin
          rxCnt <= FW'(1); rxLocked <= 1'b1;
        end else if (rxLocked) begin
          rxCnt <= rxCnt + 1'b1;
        end
      end
      if (txValid) begin
        if (txMfSync) begin
          txCnt <= FW'(1); txLocked <= 1'b1;
        end else if (txLocked) begin
          txCnt <= txCnt + 1'b1;
        end
      end
    end
  end

  // R2
  commit_on_odd_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.rxCommit |-> st.rxCapture);
  // R13
  unlocked_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rxLocked && !rxMfSync) |-> !st.rxMfBegin);
endmodule

// File: rtl/e1_spare_bits_datapath.sv
`timescale 1ns/1ps
module e1_spare_bits_datapath
  import e1_spare_bits_pkg::*;
#(
  parameter int SA    = SA_COUNT,
  parameter int SLOTS = SLOT_COUNT
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            st,
  input  logic [7:0]        rxOctet,
  input  logic              txValid,
  input  logic [7:0]        txOctet,
  input  logic [SA-1:0]     dlSel,
  input  logic [SA-1:0]     dlBits,
  input  logic [SA-1:0]     transpSel,
  input  logic              txWrEn,
  input  logic [2:0]        txWrSel,
  input  logic [SLOTS-1:0]  txWrData,
  input  logic [SA-2:0]     cosBitEn,
  input  logic [SA-1:0]     cosNibEn,
  input  logic [2:0]        stsClear,
  output logic [SA*SLOTS-1:0] rxSaBufs,
  output logic [2:0]        irqStatus,
  output logic              txLineValid,
  output logic [7:0]        txLineOctet
);
  localparam int HALF = SLOTS / 2;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic [SLOTS-1:0] rxShadow [SA];
  logic [SLOTS-1:0] rxBuf    [SA];
  logic [SLOTS-1:0] nextByte [SA];
  logic [SLOTS-1:0] txBuf    [SA];
  logic [SLOTS-1:0] txAct    [SA];
  logic primed, bitChg, hiChg, loChg;
  logic [2:0] setVec;
  logic [7:0] txBuilt;

  // receive: merge the incoming spare bits into a copy of the shadow
  always_comb begin
    for (int k = 0; k < SA; k++) begin
      nextByte[k] = rxShadow[k];
      if (st.rxCapture)
        nextByte[k][LAST_SLOT - st.rxSlot] = rxOctet[SA-1-k];
    end
  end

  // change-of-state comparison against the previous multiframe
  always_comb begin
    bitChg = 1'b0;
    hiChg  = 1'b0;
    loChg  = 1'b0;
    for (int k = 1; k < SA; k++)
      if (cosBitEn[SA-1-k] && (nextByte[k] != rxBuf[k])) bitChg = 1'b1;
    for (int k = 0; k < SA; k++) begin
      if (cosNibEn[SA-1-k] && (nextByte[k][SLOTS-1:HALF] != rxBuf[k][SLOTS-1:HALF]))
        hiChg = 1'b1;
      if (cosNibEn[SA-1-k] && (nextByte[k][HALF-1:0] != rxBuf[k][HALF-1:0]))
        loChg = 1'b1;
    end
    setVec[0] = st.rxMfBegin;
    setVec[1] = primed && st.rxCommit && bitChg;
    setVec[2] = primed && ((st.rxMidNib && hiChg) || (st.rxCommit && loChg));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < SA; k++) begin
        rxShadow[k] <= '0;
        rxBuf[k]    <= '0;
      end
      primed    <= 1'b0;
      irqStatus <= '0;
    end else begin
      if (st.rxCapture)
        for (int k = 0; k < SA; k++) rxShadow[k] <= nextByte[k];
      if (st.rxCommit) begin
        for (int k = 0; k < SA; k++) rxBuf[k] <= nextByte[k];
        primed <= 1'b1;
      end
      irqStatus <= (irqStatus & ~stsClear) | setVec;
    end
  end

  generate
    for (genvar k = 0; k < SA; k++) begin : g_flat
      assign rxSaBufs[k*SLOTS +: SLOTS] = rxBuf[k];
    end
  endgenerate

  // transmit: processor bytes, snapshot at frame 0
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < SA; k++) begin
        txBuf[k] <= '0;
        txAct[k] <= '0;
      end
    end else begin
      if (txWrEn && (int'(txWrSel) < SA)) txBuf[txWrSel] <= txWrData;
      if (st.txLoad)
        for (int k = 0; k < SA; k++) txAct[k] <= txBuf[k];
    end
  end

  always_comb begin
    txBuilt = txOctet;
    if (st.txInsert) begin
      for (int p = 0; p < SA; p++) begin
        if (dlSel[p])
          txBuilt[p] = dlBits[p];
        else if (!transpSel[p])
          txBuilt[p] = txAct[SA-1-p][LAST_SLOT - st.txSlot];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txLineValid <= 1'b0;
      txLineOctet <= '0;
    end else begin
      txLineValid <= txValid;
      if (txValid) txLineOctet <= txBuilt;
    end
  end

  // R3
  rx_atomic_chk: assert property (@(posedge clk) disable iff (!rstN)
    !st.rxCommit |=> $stable(rxSaBufs));
  // R4
  mf_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.rxMfBegin |=> irqStatus[0]);
  // R5
  bit_cos_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqStatus[1]) |-> $past(st.rxCommit));
  // R7
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stsClear[0] && !st.rxMfBegin) |=> !irqStatus[0]);
  // R9
  tx_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |=> txLineValid);
endmodule

// File: rtl/e1_spare_bits.sv
`timescale 1ns/1ps
module e1_spare_bits
  import e1_spare_bits_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic        rxMfSync,
  input  logic [7:0]  rxOctet,
  input  logic        txValid,
  input  logic        txMfSync,
  input  logic [7:0]  txOctet,
  input  logic [4:0]  dlSel,
  input  logic [4:0]  dlBits,
  input  logic [4:0]  transpSel,
  input  logic        txWrEn,
  input  logic [2:0]  txWrSel,
  input  logic [7:0]  txWrData,
  input  logic [3:0]  cosBitEn,
  input  logic [4:0]  cosNibEn,
  input  logic [2:0]  irqMask,
  input  logic [2:0]  stsClear,
  output logic [39:0] rxSaBufs,
  output logic [2:0]  irqStatus,
  output logic        irq,
  output logic        txLineValid,
  output logic [7:0]  txLineOctet
);
  strobeT st;

  e1_spare_bits_ctrl #(.FRAMES(FRAME_COUNT)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxMfSync(rxMfSync),
    .txValid(txValid), .txMfSync(txMfSync), .st(st)
  );

  e1_spare_bits_datapath #(.SA(SA_COUNT), .SLOTS(SLOT_COUNT)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .rxOctet(rxOctet),
    .txValid(txValid), .txOctet(txOctet), .dlSel(dlSel), .dlBits(dlBits),
    .transpSel(transpSel), .txWrEn(txWrEn), .txWrSel(txWrSel),
    .txWrData(txWrData), .cosBitEn(cosBitEn), .cosNibEn(cosNibEn),
    .stsClear(stsClear), .rxSaBufs(rxSaBufs), .irqStatus(irqStatus),
    .txLineValid(txLineValid), .txLineOctet(txLineOctet)
  );

  assign irq = |(irqStatus & irqMask);
endmodule

// File: tb/e1_spare_bits_test.sv
`timescale 1ns/1ps
module e1_spare_bits_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxValid = 0, rxMfSync = 0, txValid = 0, txMfSync = 0, txWrEn = 0;
  logic [7:0] rxOctet = 0, txOctet = 0, txWrData = 0;
  logic [4:0] dlSel = 0, dlBits = 0, transpSel = 0, cosNibEn = 0;
  logic [3:0] cosBitEn = 0;
  logic [2:0] txWrSel = 0, irqMask = 0, stsClear = 0;
  logic [39:0] rxSaBufs;
  logic [2:0] irqStatus;
  logic irq, txLineValid;
  logic [7:0] txLineOctet;

  int checks = 0, errors = 0;
  bit finished = 0;

  // bench model state
  logic [7:0] mBuf [5];
  logic [7:0] mTxBuf [5];
  logic [7:0] mTxAct [5];
  logic [2:0] mSts = 0;
  bit mPrimed = 0, mRxLocked = 0, mTxLocked = 0;

  always #2.5 clk = ~clk;

  e1_spare_bits uut (.*);

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [39:0] flatBufs();
    logic [39:0] r;
    for (int k = 0; k < 5; k++) r[k*8 +: 8] = mBuf[k];
    return r;
  endfunction

  task automatic clearSts(input logic [2:0] v);
    @(negedge clk); stsClear = v;
    @(negedge clk); stsClear = 0;
    mSts = mSts & ~v;
  endtask

  task automatic rxMf(input logic [7:0] sa [5], input bit sync, input logic [2:0] clrAt0);
    for (int f = 0; f < 16; f++) begin
      logic [7:0] oct;
      logic [2:0] clrNow;
      logic [2:0] setNow;
      oct = 8'($urandom);
      clrNow = (f == 0) ? clrAt0 : 3'b0;
      setNow = 3'b0;
      if (f % 2 == 1)
        for (int p = 0; p < 5; p++) oct[p] = sa[4-p][7-(f-1)/2];
      if (sync && f == 0) mRxLocked = 1;
      if (mRxLocked) begin
        if (f == 0) setNow[0] = 1;
        if (f == 7 && mPrimed)
          for (int k = 0; k < 5; k++)
            if (cosNibEn[4-k] && sa[k][7:4] != mBuf[k][7:4]) setNow[2] = 1;
        if (f == 15 && mPrimed) begin
          for (int k = 0; k < 5; k++)
            if (cosNibEn[4-k] && sa[k][3:0] != mBuf[k][3:0]) setNow[2] = 1;
          for (int k = 1; k < 5; k++)
            if (cosBitEn[4-k] && sa[k] != mBuf[k]) setNow[1] = 1;
        end
      end
      @(negedge clk);
      rxValid = 1; rxOctet = oct; rxMfSync = sync && (f == 0); stsClear = clrNow;
      @(negedge clk);
      rxValid = 0; rxMfSync = 0; stsClear = 0;
      mSts = (mSts & ~clrNow) | setNow;
      if (f == 15 && mRxLocked) begin
        for (int k = 0; k < 5; k++) mBuf[k] = sa[k];
        mPrimed = 1;
      end
      if (f == 8) check(rxSaBufs == flatBufs(), "R3 mid-multiframe read", rxSaBufs, flatBufs());
    end
    check(rxSaBufs == flatBufs(), "R2 committed bytes", rxSaBufs, flatBufs());
    check(irqStatus[0] == mSts[0], "R4 multiframe status", irqStatus, mSts);
    check(irqStatus[1] == mSts[1], "R5 byte change status", irqStatus, mSts);
    check(irqStatus[2] == mSts[2], "R6 nibble change status", irqStatus, mSts);
  endtask

  task automatic txWrite(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk); txWrEn = 1; txWrSel = sel; txWrData = d;
    @(negedge clk); txWrEn = 0;
    if (sel < 5) mTxBuf[sel] = d;
  endtask

  task automatic txFrame(input logic [7:0] oct, input bit sync, input int f, input string tag);
    logic [7:0] exp;
    if (sync) mTxLocked = 1;
    if (mTxLocked && f == 0)
      for (int k = 0; k < 5; k++) mTxAct[k] = mTxBuf[k];
    exp = oct;
    if (mTxLocked && (f % 2 == 1))
      for (int p = 0; p < 5; p++)
        if (dlSel[p]) exp[p] = dlBits[p];
        else if (!transpSel[p]) exp[p] = mTxAct[4-p][7-(f-1)/2];
    @(negedge clk); txValid = 1; txOctet = oct; txMfSync = sync;
    @(negedge clk); txValid = 0; txMfSync = 0;
    check(txLineValid && txLineOctet == exp, tag, {txLineValid, txLineOctet}, {1'b1, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] sa [5];
    logic [7:0] prev [5];
    void'($urandom(32'h2468ACE1));
    for (int k = 0; k < 5; k++) begin mBuf[k] = 0; mTxBuf[k] = 0; mTxAct[k] = 0; end
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(rxSaBufs == 0, "R1 reset bytes", rxSaBufs, 0);
    check(irqStatus == 0 && !irq, "R1 reset status", {irq, irqStatus}, 0);
    check(!txLineValid, "R1 reset tx valid", txLineValid, 0);

    // R13: no sync yet on either side
    cosBitEn = 4'hF; cosNibEn = 5'h1F; irqMask = 3'b111;
    for (int k = 0; k < 5; k++) sa[k] = 8'($urandom);
    rxMf(sa, 0, 3'b0);
    check(rxSaBufs == 0 && irqStatus == 0, "R13 rx before sync", {rxSaBufs, irqStatus}, 0);
    for (int f = 0; f < 4; f++) txFrame(8'($urandom), 0, f, "R13 tx before sync");

    // first locked multiframe, no comparison yet
    for (int k = 0; k < 5; k++) sa[k] = 8'($urandom);
    rxMf(sa, 1, 3'b0);
    check(irq == 1, "R8 irq with status and mask", irq, 1);
    irqMask = 3'b110;
    @(negedge clk);
    check(irq == ((mSts & irqMask) != 0), "R8 irq masked", irq, (mSts & irqMask) != 0);
    irqMask = 3'b111;
    clearSts(3'b111);
    check(irqStatus == 0 && !irq, "R7 write-one-to-clear", irqStatus, 0);

    // random multiframes with partial changes
    for (int i = 0; i < 10; i++) begin
      cosBitEn = 4'($urandom); cosNibEn = 5'($urandom);
      for (int k = 0; k < 5; k++) begin
        prev[k] = mBuf[k];
        case ($urandom % 3)
          0: sa[k] = prev[k];
          1: sa[k] = prev[k] ^ (8'h1 << ($urandom % 8));
          default: sa[k] = 8'($urandom);
        endcase
      end
      rxMf(sa, (i == 5), 3'b0);
      clearSts(3'b111);
    end

    // Sa4 excluded from the byte change
    cosBitEn = 4'hF; cosNibEn = 5'h00;
    for (int k = 0; k < 5; k++) sa[k] = mBuf[k];
    sa[0] = ~mBuf[0];
    rxMf(sa, 0, 3'b0);
    check(irqStatus[1] == 0, "R5 Sa4 change ignored", irqStatus, 3'b001);
    clearSts(3'b111);

    // lower nibble of Sa7 only, nibble enable on Sa7 only
    cosBitEn = 4'h0; cosNibEn = 5'b00010;
    for (int k = 0; k < 5; k++) sa[k] = mBuf[k];
    sa[3] = mBuf[3] ^ 8'h05;
    rxMf(sa, 0, 3'b0);
    check(irqStatus == 3'b101, "R6 low nibble change", irqStatus, 3'b101);

    // set wins over clear on the frame-0 cycle
    rxMf(sa, 0, 3'b111);
    check(irqStatus[0] == 1, "R7 set beats clear", irqStatus, 3'b001);
    clearSts(3'b111);

    // transmit: buffers, then random selections
    for (int k = 0; k < 5; k++) txWrite(3'(k), 8'($urandom));
    for (int m = 0; m < 4; m++) begin
      for (int f = 0; f < 16; f++) begin
        if (m >= 2) begin dlSel = 5'($urandom); dlBits = 5'($urandom); transpSel = 5'($urandom); end
        txFrame(8'($urandom), (m == 0 && f == 0), f,
                dlSel != 0 ? "R11 data link select" : (transpSel != 0 ? "R10 transparent select" : "R9 buffer insert"));
        if (m == 1 && f == 6) begin
          txWrite(3'd2, 8'($urandom));
          txWrite(3'd7, 8'hFF);
        end
      end
    end

    // directed: data link beats transparent
    dlSel = 5'h1F; transpSel = 5'h1F; dlBits = 5'b10110;
    txFrame(8'h00, 1, 0, "R11 frame 0 unchanged");
    txFrame(8'h00, 0, 1, "R11 data link over transparent");
    // directed: write mid multiframe stays inactive until frame 0
    dlSel = 0; transpSel = 0;
    txWrite(3'd4, 8'hFF);
    txFrame(8'h00, 0, 2, "R12 even frame");
    txFrame(8'h00, 0, 3, "R12 old byte still active");
    for (int f = 4; f < 16; f++) txFrame(8'($urandom), 0, f, "R9 buffer insert");
    txFrame(8'h00, 0, 0, "R12 snapshot frame");
    txFrame(8'h00, 0, 1, "R12 new byte active");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule